// File: doc/BRIEF.md
# 2B1Q Transmit Framer and Quaternary Encoder

This block produces the outgoing quaternary symbol stream of a 160 kbit/s basic-rate subscriber line transceiver. Each time the 80 kHz symbol tick arrives, it emits one symbol code with a one-cycle valid strobe. The code is two bits wide: the upper bit carries the sign and the lower bit the magnitude. The digital-to-analog stage downstream turns the code into a line level.

In data mode the block builds 120-quat frames. Each frame opens with a 9-quat synchronisation word. The first frame of every eight-frame superframe uses the polarity-inverted word. Twelve payload groups follow, each holding B1, B2 and D bits. Six M-channel bits close the frame. Every payload bit passes through a self-synchronising scrambler before it is mapped to a symbol. The scrambler taps depend on the line end: terminal-side taps or network-side taps. The sync word does not pass through the scrambler.

Two further modes support link activation. Tone mode repeats four +3 symbols and then four −3 symbols, which gives a 10 kHz tone. Quiet mode sends a zero-level symbol and flags it with a separate no-signal output. Frame position restarts whenever the block leaves data mode, so each entry into data mode begins with a full superframe.

Top module: `quat_line_framer`

## Requirements
- R1: The symbol code is {sign, magnitude}: 2'b10 = +3, 2'b11 = +1, 2'b01 = −1, 2'b00 = −3. The sync word is +3,+3,−3,−3,−3,+3,−3,+3,+3 and occupies frame quats 0–8, sent unscrambled.
- R2: In frame 0 of each eight-frame superframe, every sync quat has the opposite polarity. `superStart` is high, together with `frameStart`, on that frame's first quat.
- R3: A frame is exactly 120 quats long. `frameStart` is high, with `symValid`, only on quat 0 of each frame in data mode.
- R4: Frame quats 9–116 hold twelve groups of 9 quats. Each group carries `b1Data` bit 7 down to bit 0, then `b2Data` bit 7 down to bit 0, then `dData` bit 1 then bit 0. Bits are paired in that order, with the first bit of each pair as the sign. Quats 117–119 carry `mData` bit 5 down to bit 0.
- R5: With `ntMode` = 0, each payload bit is scrambled as out = in ⊕ out(n−5) ⊕ out(n−23). The scrambler state is all ones after reset and advances only on payload bits.
- R6: With `ntMode` = 1, the scrambler uses out = in ⊕ out(n−18) ⊕ out(n−23).
- R7: With `txMode` = 2'b01, the output is four +3 symbols followed by four −3 symbols, repeating. The pattern starts with +3 on the first tick in tone mode.
- R8: With `txMode` = 2'b00 or 2'b11, the code is 2'b00, `noSignal` is 1, and the scrambler does not advance.
- R9: `symValid` is high for exactly the one cycle after each cycle in which `quatTick` is high, and is low at all other times.
- R10: On the first tick in data mode (`txMode` = 2'b10) after any other mode, the block emits quat 0 of superframe frame 0.
- R11: While `rstN` is low, and after it is released until the first tick, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| quatTick | input | 1 | One-cycle symbol-rate strobe (80 kHz) |
| ntMode | input | 1 | 0 = terminal-side scrambler, 1 = network-side scrambler |
| txMode | input | 2 | 00 quiet, 01 tone, 10 data, 11 quiet |
| b1Data | input | 8 | B1 byte, sampled on ticks |
| b2Data | input | 8 | B2 byte, sampled on ticks |
| dData | input | 2 | D bits, sampled on ticks |
| mData | input | 6 | M-channel bits for the frame tail |
| symCode | output | 2 | Symbol code {sign, magnitude} |
| symValid | output | 1 | High one cycle per emitted symbol |
| noSignal | output | 1 | Emitted symbol is silence |
| frameStart | output | 1 | Emitted symbol is the first sync quat |
| superStart | output | 1 | Emitted symbol begins a superframe |

## Verification
The hardest condition to reach from the ports is a scrambler state that has survived a stretch of quiet and tone symbols and must then resume exactly where it stopped. A wrong advance during silence only appears later, as corrupted payload. The stimulus runs more than two superframes of data, then quiet, then tone, and then returns to data. Any slip in the scrambler then shows up in the payload symbols that follow, and the superframe restart is visible at the same time. The network-side taps are exercised after a second reset, so that both tap positions start from a known all-ones state.

// File: rtl/quat_pkg.sv
package quat_pkg;
  localparam int GROUP_QUATS = 9;
  localparam int SYNC_QUATS  = 9;
  localparam logic [8:0] SYNC_WORD = 9'b110001011;

  typedef enum logic [1:0] {
    MODE_QUIET = 2'b00,
    MODE_TONE  = 2'b01,
    MODE_DATA  = 2'b10,
    MODE_IDLE  = 2'b11
  } txMode_e;

  typedef enum logic [2:0] {
    K_QUIET, K_TONE_HI, K_TONE_LO, K_SYNC, K_PAY, K_MCH
  } quatKind_e;

  typedef struct packed {
    logic      step;
    quatKind_e kind;
    logic [3:0] slot;
    logic      invSync;
    logic      frameFirst;
  } ctrlStrobe_t;
endpackage

// File: rtl/quat_ctrl.sv
module quat_ctrl
  import quat_pkg::*;
#(
  parameter int GROUPS       = 12,
  parameter int SUPER_FRAMES = 8,
  parameter int M_QUATS      = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        quatTick,
  input  logic [1:0]  txMode,
  output ctrlStrobe_t strobe
);
  localparam int SEG_LAST = GROUPS + 1;
  localparam int SEG_W    = $clog2(GROUPS + 2);
  localparam int FR_W     = (SUPER_FRAMES > 1) ? $clog2(SUPER_FRAMES) : 1;

  logic [SEG_W-1:0] segIdx;
  logic [3:0]       quatIdx;
  logic [FR_W-1:0]  frameIdx;
  logic [2:0]       tonePhase;
  logic             isLastSeg;
  logic [3:0]       lastQuat;

  always_comb begin
    isLastSeg = (segIdx == SEG_W'(SEG_LAST));
    lastQuat  = isLastSeg ? 4'(M_QUATS - 1) : 4'(GROUP_QUATS - 1);
    strobe.step       = quatTick;
    strobe.slot       = quatIdx;
    strobe.invSync    = (frameIdx == '0);
    strobe.frameFirst = (segIdx == '0) && (quatIdx == '0);
    case (txMode)
      MODE_DATA: begin
        if (segIdx == '0)   strobe.kind = K_SYNC;
        else if (isLastSeg) strobe.kind = K_MCH;
        else                strobe.kind = K_PAY;
      end
      MODE_TONE: strobe.kind = tonePhase[2] ? K_TONE_LO : K_TONE_HI;
      default:   strobe.kind = K_QUIET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segIdx    <= '0;
      quatIdx   <= '0;
      frameIdx  <= '0;
      tonePhase <= '0;
    end else if (quatTick) begin
      tonePhase <= (txMode == MODE_TONE) ? tonePhase + 3'd1 : 3'd0;
      if (txMode != MODE_DATA) begin
        segIdx   <= '0;
        quatIdx  <= '0;
        frameIdx <= '0;
      end else if (quatIdx == lastQuat) begin
        quatIdx <= '0;
        if (isLastSeg) begin
          segIdx   <= '0;
          frameIdx <= (frameIdx == FR_W'(SUPER_FRAMES - 1)) ? '0 : frameIdx + 1'b1;
        end else begin
          segIdx <= segIdx + 1'b1;
        end
      end else begin
        quatIdx <= quatIdx + 4'd1;
      end
    end
  end

  // Tone pattern: a high half is followed by a low half after four tone ticks
  assert_tone_half_R7: assert property (@(posedge clk) disable iff (!rstN)
    (quatTick && txMode == MODE_TONE && tonePhase == 3'd3) |=> (tonePhase == 3'd4));
endmodule

// File: rtl/quat_dpath.sv
module quat_dpath
  import quat_pkg::*;
#(
  parameter int SCR_LEN = 23,
  parameter int LT_TAP  = 5,
  parameter int NT_TAP  = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        ntMode,
  input  logic [7:0]  b1Data,
  input  logic [7:0]  b2Data,
  input  logic [1:0]  dData,
  input  logic [5:0]  mData,
  output logic [1:0]  symCode,
  output logic        symValid,
  output logic        noSignal,
  output logic        frameStart,
  output logic        superStart
);
  logic [SCR_LEN-1:0] scrReg, scrMid, scrNext;
  logic [17:0] grpVec;
  logic [4:0]  idxA;
  logic [2:0]  mIdxA;
  logic        bitA, bitB, scrA, scrB, syncBit;
  logic [1:0]  codeNext;
  logic        isPayload;

  function automatic logic [SCR_LEN:0] scrStep(input logic [SCR_LEN-1:0] st,
                                               input logic din, input logic nt);
    logic fb;
    fb = din ^ (nt ? st[NT_TAP-1] : st[LT_TAP-1]) ^ st[SCR_LEN-1];
    return {st[SCR_LEN-2:0], fb, fb};
  endfunction

  always_comb begin
    grpVec    = {b1Data, b2Data, dData};
    idxA      = 5'd17 - {strobe.slot, 1'b0};
    mIdxA     = 3'd5 - {strobe.slot[1:0], 1'b0};
    isPayload = (strobe.kind == K_PAY) || (strobe.kind == K_MCH);
    if (strobe.kind == K_MCH) begin
      bitA = mData[mIdxA];
      bitB = mData[mIdxA - 3'd1];
    end else begin
      bitA = grpVec[idxA];
      bitB = grpVec[idxA - 5'd1];
    end
    {scrMid, scrA}  = scrStep(scrReg, bitA, ntMode);
    {scrNext, scrB} = scrStep(scrMid, bitB, ntMode);
    syncBit = SYNC_WORD[4'd8 - strobe.slot] ^ strobe.invSync;
    case (strobe.kind)
      K_SYNC:    codeNext = {syncBit, 1'b0};
      K_PAY,
      K_MCH:     codeNext = {scrA, scrB};
      K_TONE_HI: codeNext = 2'b10;
      default:   codeNext = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrReg     <= '1;
      symCode    <= '0;
      symValid   <= 1'b0;
      noSignal   <= 1'b0;
      frameStart <= 1'b0;
      superStart <= 1'b0;
    end else begin
      symValid   <= strobe.step;
      frameStart <= strobe.step && strobe.kind == K_SYNC && strobe.frameFirst;
      superStart <= strobe.step && strobe.kind == K_SYNC && strobe.frameFirst && strobe.invSync;
      if (strobe.step) begin
        symCode  <= codeNext;
        noSignal <= (strobe.kind == K_QUIET);
        if (isPayload) scrReg <= scrNext;
      end
    end
  end

  assert_scr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step && isPayload) |=> $stable(scrReg));
  assert_valid_after_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> $past(strobe.step));
  assert_sync_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (symValid && symCode[0] == 1'b0));
  assert_super_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    superStart |-> frameStart);
  assert_quiet_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    noSignal |-> (symCode == 2'b00));
endmodule

// File: rtl/quat_line_framer.sv
module quat_line_framer
  import quat_pkg::*;
#(
  parameter int GROUPS       = 12,
  parameter int SUPER_FRAMES = 8,
  parameter int M_QUATS      = 3,
  parameter int SCR_LEN      = 23,
  parameter int LT_TAP       = 5,
  parameter int NT_TAP       = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       quatTick,
  input  logic       ntMode,
  input  logic [1:0] txMode,
  input  logic [7:0] b1Data,
  input  logic [7:0] b2Data,
  input  logic [1:0] dData,
  input  logic [5:0] mData,
  output logic [1:0] symCode,
  output logic       symValid,
  output logic       noSignal,
  output logic       frameStart,
  output logic       superStart
);
  localparam int FRAME_QUATS = SYNC_QUATS + GROUPS * GROUP_QUATS + M_QUATS;
  localparam int GAP_W       = $clog2(FRAME_QUATS + 1);

  ctrlStrobe_t strobe;

  quat_ctrl #(.GROUPS(GROUPS), .SUPER_FRAMES(SUPER_FRAMES), .M_QUATS(M_QUATS)) ctrl_i (
    .clk(clk), .rstN(rstN), .quatTick(quatTick), .txMode(txMode), .strobe(strobe));

  quat_dpath #(.SCR_LEN(SCR_LEN), .LT_TAP(LT_TAP), .NT_TAP(NT_TAP)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ntMode(ntMode),
    .b1Data(b1Data), .b2Data(b2Data), .dData(dData), .mData(mData),
    .symCode(symCode), .symValid(symValid), .noSignal(noSignal),
    .frameStart(frameStart), .superStart(superStart));

  // Frame-length watch: quats emitted since the last frame opening in an unbroken data run
  logic [GAP_W-1:0] gapCnt;
  logic             inRun;
  logic             isDataKind, isOpening;

  always_comb begin
    isDataKind = strobe.kind == K_SYNC || strobe.kind == K_PAY || strobe.kind == K_MCH;
    isOpening  = strobe.kind == K_SYNC && strobe.frameFirst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
      inRun  <= 1'b0;
    end else if (strobe.step) begin
      if (isOpening) begin
        inRun  <= 1'b1;
        gapCnt <= GAP_W'(1);
      end else if (isDataKind) begin
        gapCnt <= gapCnt + 1'b1;
      end else begin
        inRun <= 1'b0;
      end
    end
  end

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && isOpening && inRun) |-> (gapCnt == GAP_W'(FRAME_QUATS)));
endmodule

// File: tb/quat_line_framer_tb.sv
`timescale 1ns/1ps
module quat_line_framer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic quatTick = 1'b0;
  logic ntMode = 1'b0;
  logic [1:0] txMode = 2'b00;
  logic [7:0] b1Data = '0, b2Data = '0;
  logic [1:0] dData = '0;
  logic [5:0] mData = '0;
  logic [1:0] symCode;
  logic symValid, noSignal, frameStart, superStart;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  int mPos = 0, mFrame = 0, mPhase = 0;
  logic [22:0] mScr = '1;
  bit lastWasData = 0;
  int swLevel [9] = '{3, 3, -3, -3, -3, 3, -3, 3, 3};

  always #2.5 clk = ~clk;

  quat_line_framer dut_i (
    .clk(clk), .rstN(rstN), .quatTick(quatTick), .ntMode(ntMode), .txMode(txMode),
    .b1Data(b1Data), .b2Data(b2Data), .dData(dData), .mData(mData),
    .symCode(symCode), .symValid(symValid), .noSignal(noSignal),
    .frameStart(frameStart), .superStart(superStart));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d frame %0d)", req, act, exp, mPos, mFrame);
    end
  endtask

  function automatic logic scrBit(input logic din);
    int tap;
    logic fb;
    tap = ntMode ? 18 : 5;
    fb = din ^ mScr[tap-1] ^ mScr[22];
    mScr = {mScr[21:0], fb};
    return fb;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(symValid == 0 && symCode == 0 && noSignal == 0 && frameStart == 0 && superStart == 0,
        "R11", {symValid, symCode, noSignal, frameStart, superStart}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(symValid == 0 && symCode == 0 && noSignal == 0 && frameStart == 0 && superStart == 0,
        "R11", {symValid, symCode, noSignal, frameStart, superStart}, 0);
    mPos = 0; mFrame = 0; mPhase = 0; mScr = '1; lastWasData = 0;
  endtask

  task automatic tick();
    logic [1:0] expCode;
    bit expNs, expFs, expSs, a, b, sa, sb;
    string req;
    logic [17:0] vec;
    int off, k;
    expNs = 0; expFs = 0; expSs = 0;
    if (txMode == 2'b10) begin
      mPhase = 0;
      if (mPos < 9) begin
        a = (swLevel[mPos] > 0) ^ (mFrame == 0);
        expCode = {a, 1'b0};
        expFs = (mPos == 0);
        expSs = (mPos == 0) && (mFrame == 0);
        req = !lastWasData ? "R10" : (mFrame == 0 ? "R2" : "R1");
      end else begin
        if (mPos < 117) begin
          off = mPos - 9; k = off % 9;
          vec = {b1Data, b2Data, dData};
          a = vec[17 - 2*k]; b = vec[16 - 2*k];
        end else begin
          k = mPos - 117;
          a = mData[5 - 2*k]; b = mData[4 - 2*k];
        end
        sa = scrBit(a); sb = scrBit(b);
        expCode = {sa, sb};
        req = ntMode ? "R6 R4" : "R5 R4";
      end
      lastWasData = 1;
    end else begin
      lastWasData = 0;
      if (txMode == 2'b01) begin
        expCode = (mPhase < 4) ? 2'b10 : 2'b00;
        mPhase = (mPhase + 1) % 8;
        req = "R7";
      end else begin
        mPhase = 0;
        expCode = 2'b00;
        expNs = 1;
        req = "R8";
      end
    end
    @(negedge clk);
    quatTick = 1'b1;
    @(negedge clk);
    quatTick = 1'b0;
    chk(symValid == 1, "R9", symValid, 1);
    chk(symCode == expCode, req, symCode, expCode);
    chk(noSignal == expNs, "R8", noSignal, expNs);
    chk(frameStart == expFs, "R3", frameStart, expFs);
    chk(superStart == expSs, "R2", superStart, expSs);
    if (txMode == 2'b10) begin
      mPos++;
      if (mPos == 120) begin
        mPos = 0;
        mFrame = (mFrame + 1) % 8;
      end
    end else begin
      mPos = 0; mFrame = 0;
    end
    @(negedge clk);
    chk(symValid == 0, "R9", symValid, 0);
  endtask

  task automatic runData(input int frames, input int seed);
    txMode = 2'b10;
    for (int f = 0; f < frames; f++) begin
      b1Data = 8'((f + seed) * 37 + 5);
      b2Data = 8'((f + seed) * 91 + 200);
      dData  = 2'(f + seed);
      mData  = 6'((f + seed) * 13 + 1);
      for (int q = 0; q < 120; q++) begin
        if (q == 40) begin
          b1Data = ~b1Data;
          dData  = dData + 2'd1;
        end
        tick();
      end
    end
  endtask

  task automatic runOther(input logic [1:0] mode, input int n);
    txMode = mode;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    doReset();
    ntMode = 1'b0;
    runData(17, 0);
    runOther(2'b00, 25);
    runOther(2'b01, 20);
    runData(2, 3);
    runOther(2'b11, 5);
    runOther(2'b01, 3);
    runData(1, 7);
    ntMode = 1'b1;
    doReset();
    runData(9, 11);
    runOther(2'b00, 4);
    runData(1, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule